// File: doc/BRIEF.md
# Dual-Clock Ping-Pong Scanline Buffer

This block holds two scanlines of pixel words between a memory clock domain and a pixel clock domain. While the pixel side streams one bank out at pixel rate, the memory side fills the other bank with the next raster line. It fills in a short burst, at whatever rate the external memory controller delivers words. The gaps between bursts leave the memory free for other masters.

A horizontal-sync pulse in the pixel domain swaps the two banks. The swap is carried into the memory domain as a toggle through a two-flop synchronizer. The memory side then raises a new line request. Its address is the base address plus the line number times the row stride, and the line number wraps at the frame height. A fill-done status reports that the whole line has landed. A sticky late flag records any swap that arrived before the fill was complete. In that case the bank shown is the stale one.

Top module: `scanline_pingpong_buf`

## Requirements
- R1: After reset the block requests line 0, with `req_valid` high and `req_addr` equal to `base_addr`. `fill_done` and `late_line` are low, and `pix_valid` is low.
- R2: A pending request keeps `req_valid` high and `req_addr` stable until `req_ready` accepts it or a bank swap replaces it. It drops in the cycle after acceptance.
- R3: After a request is accepted, exactly LINE_PIXELS words marked by `wr_valid` are written, in order, to the bank not on display. Idle cycles between words are allowed. `fill_done` rises one memory clock after the last word. Words arriving after that are discarded.
- R4: A cycle with `pix_en` high, and `hsync` low, yields `pix_valid` high one pixel clock later. The accompanying `pix_data` is word k of the shown bank, where k counts enabled cycles since the last `hsync`.
- R5: Each `hsync` pulse swaps the banks, so the line filled during the previous line period is the one streamed after the pulse. The cycle after `hsync` has `pix_valid` low.
- R6: Each swap issues a new request at address `base_addr + n*row_stride`, where n is the previous line number plus one. n wraps to 0 after NUM_LINES-1.
- R7: A swap that arrives while `fill_done` is low sets `late_line`, which stays high until reset. The bank then shown holds its older contents.
- R8: A swap clears `fill_done` in the next memory clock cycle.
- R9: `wr_valid` words presented before the pending request is accepted are discarded and reach no bank.
- R10: Every `hsync` pulse gives exactly one swap in the memory domain, provided pulses are at least 8 memory clocks apart. The line number then advances by exactly one per pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mem_clk | input | 1 | Memory-domain clock |
| mem_rst_n | input | 1 | Memory-domain asynchronous reset, active low |
| base_addr | input | ADDR_W | Address of line 0 of the frame |
| row_stride | input | STRIDE_W | Address distance between successive lines |
| req_valid | output | 1 | Line request pending |
| req_ready | input | 1 | Memory controller accepts the request |
| req_addr | output | ADDR_W | Start address of the requested line |
| wr_valid | input | 1 | A pixel word of the burst is present |
| wr_data | input | PIX_W | Pixel word from memory |
| fill_done | output | 1 | Whole line has been written into the fill bank |
| late_line | output | 1 | Sticky: a swap hit an incomplete fill |
| pix_clk | input | 1 | Pixel clock |
| pix_rst_n | input | 1 | Pixel-domain asynchronous reset, active low |
| hsync | input | 1 | One-cycle line-start pulse, swaps the banks |
| pix_en | input | 1 | Fetch the next pixel of the shown line |
| pix_valid | output | 1 | `pix_data` carries a pixel |
| pix_data | output | PIX_W | Pixel word out |

## Verification
Several results are due a fixed number of cycles after their stimulus. `pix_data` and `pix_valid` follow `pix_en` by one pixel clock, and `fill_done` follows the last accepted word by one memory clock. A request drops one memory clock after its `req_ready`. Those checks sample on the falling edge right after the capturing rising edge. A swap crosses domains: it reaches the memory side within two to four memory clocks of the `hsync` edge, and its request, `fill_done` clear and late flag appear one clock later. The bench therefore waits a fixed eight memory clocks after each pulse before checking any memory-side result. That window exceeds the worst case, yet stays well below the spacing between pulses.

// File: rtl/lb_pkg.sv
package lb_pkg;

    typedef enum logic {
        BANK_A = 1'b0,
        BANK_B = 1'b1
    } bank_e;

    function automatic bank_e other_bank(bank_e b);
        return (b == BANK_A) ? BANK_B : BANK_A;
    endfunction

endpackage

// File: rtl/lb_toggle_sync.sv
module lb_toggle_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic level,
    output logic pulse
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = tog_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.s2;
    assign pulse = st_q.s2 ^ st_q.s3;

    // R10: pulses well apart never give a double swap
    a_r10_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);

endmodule

// File: rtl/lb_dpram.sv
module lb_dpram #(
    parameter int W     = 16,
    parameter int DEPTH = 640,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             wen,
    input  logic             wbank,
    input  logic [PTR_W-1:0] waddr,
    input  logic [W-1:0]     wdata,
    input  logic             rclk,
    input  logic             ren,
    input  logic             rbank,
    input  logic [PTR_W-1:0] raddr,
    output logic [W-1:0]     rdata
);
    logic [W-1:0] q_bank [2];
    logic         rsel_q;

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic [W-1:0] cells [DEPTH];

        always_ff @(posedge wclk) begin
            if (wen && (wbank == 1'(b))) cells[waddr] <= wdata;
        end

        always_ff @(posedge rclk) begin
            if (ren) q_bank[b] <= cells[raddr];
        end
    end

    always_ff @(posedge rclk) begin
        if (ren) rsel_q <= rbank;
    end

    assign rdata = rsel_q ? q_bank[1] : q_bank[0];

endmodule

// File: rtl/lb_mem_side.sv
module lb_mem_side
    import lb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int STRIDE_W    = 16,
    parameter int LINE_PIXELS = 640,
    parameter int NUM_LINES   = 480,
    parameter int PTR_W       = $clog2(LINE_PIXELS),
    parameter int LINE_W      = $clog2(NUM_LINES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] row_stride,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    input  logic                wr_valid,
    input  logic                swap,
    input  logic                disp_level,
    output logic                we,
    output logic                we_bank,
    output logic [PTR_W-1:0]    we_addr,
    output logic                fill_done,
    output logic                late_line
);
    localparam logic [PTR_W-1:0]  LAST_PTR  = PTR_W'(LINE_PIXELS - 1);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(NUM_LINES - 1);

    typedef struct packed {
        bank_e              bank;
        logic [LINE_W-1:0]  line;
        logic [PTR_W-1:0]   ptr;
        logic               issue;
        logic               pending;
        logic               filling;
        logic               done;
        logic               late;
        logic [ADDR_W-1:0]  addr;
    } mem_st_t;

    mem_st_t          st_d, st_q;
    logic [LINE_W-1:0] next_line;

    function automatic logic [ADDR_W-1:0] line_addr(logic [LINE_W-1:0] ln,
                                                    logic [ADDR_W-1:0] base,
                                                    logic [STRIDE_W-1:0] stride);
        return base + ADDR_W'(ln) * ADDR_W'(stride);
    endfunction

    always_comb begin
        st_d      = st_q;
        we        = 1'b0;
        next_line = (st_q.line == LAST_LINE) ? '0 : st_q.line + 1'b1;
        if (swap) begin
            if (!st_q.done) st_d.late = 1'b1;
            st_d.bank    = other_bank(bank_e'(disp_level));
            st_d.line    = next_line;
            st_d.addr    = line_addr(next_line, base_addr, row_stride);
            st_d.issue   = 1'b0;
            st_d.pending = 1'b1;
            st_d.filling = 1'b0;
            st_d.done    = 1'b0;
            st_d.ptr     = '0;
        end else begin
            if (st_q.issue) begin
                st_d.issue   = 1'b0;
                st_d.pending = 1'b1;
                st_d.addr    = line_addr(st_q.line, base_addr, row_stride);
            end
            if (st_q.pending && req_ready) begin
                st_d.pending = 1'b0;
                st_d.filling = 1'b1;
            end
            if (st_q.filling && wr_valid) begin
                we = 1'b1;
                if (st_q.ptr == LAST_PTR) begin
                    st_d.filling = 1'b0;
                    st_d.done    = 1'b1;
                end else begin
                    st_d.ptr = st_q.ptr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.bank  <= BANK_B;
            st_q.issue <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_valid = st_q.pending;
    assign req_addr  = st_q.addr;
    assign we_bank   = st_q.bank;
    assign we_addr   = st_q.ptr;
    assign fill_done = st_q.done;
    assign late_line = st_q.late;

    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready && !swap) |=> (req_valid && $stable(req_addr)));
    a_r2_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !swap) |=> !req_valid);
    a_r3_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_done) |-> $past(wr_valid));
    a_r6_req_after_swap: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> req_valid);
    a_r7_late_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        late_line |=> late_line);
    a_r8_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        swap |=> !fill_done);

endmodule

// File: rtl/lb_pix_side.sv
module lb_pix_side
    import lb_pkg::*;
#(
    parameter int LINE_PIXELS = 640,
    parameter int PTR_W       = $clog2(LINE_PIXELS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync,
    input  logic             pix_en,
    output logic             tog,
    output logic             ren,
    output logic             rbank,
    output logic [PTR_W-1:0] raddr,
    output logic             pix_valid
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(LINE_PIXELS - 1);

    typedef struct packed {
        bank_e            bank;
        logic             tog;
        logic [PTR_W-1:0] ptr;
        logic             valid;
    } pix_st_t;

    pix_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (hsync) begin
            st_d.bank = other_bank(st_q.bank);
            st_d.tog  = ~st_q.tog;
            st_d.ptr  = '0;
        end else if (pix_en) begin
            st_d.valid = 1'b1;
            st_d.ptr   = (st_q.ptr == LAST_PTR) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.bank <= BANK_A;
        end else begin
            st_q <= st_d;
        end
    end

    assign tog       = st_q.tog;
    assign ren       = pix_en && !hsync;
    assign rbank     = st_q.bank;
    assign raddr     = st_q.ptr;
    assign pix_valid = st_q.valid;

    a_r4_valid_follows_en: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> $past(pix_en));
    a_r5_gap_after_hsync: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> !pix_valid);

endmodule

// File: rtl/scanline_pingpong_buf.sv
module scanline_pingpong_buf #(
    parameter int PIX_W       = 16,
    parameter int LINE_PIXELS = 640,
    parameter int NUM_LINES   = 480,
    parameter int ADDR_W      = 32,
    parameter int STRIDE_W    = 16
) (
    input  logic                mem_clk,
    input  logic                mem_rst_n,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [STRIDE_W-1:0] row_stride,
    output logic                req_valid,
    input  logic                req_ready,
    output logic [ADDR_W-1:0]   req_addr,
    input  logic                wr_valid,
    input  logic [PIX_W-1:0]    wr_data,
    output logic                fill_done,
    output logic                late_line,
    input  logic                pix_clk,
    input  logic                pix_rst_n,
    input  logic                hsync,
    input  logic                pix_en,
    output logic                pix_valid,
    output logic [PIX_W-1:0]    pix_data
);
    localparam int PTR_W  = $clog2(LINE_PIXELS);
    localparam int LINE_W = $clog2(NUM_LINES);

    logic             tog, disp_level, swap;
    logic             we, we_bank, ren, rbank;
    logic [PTR_W-1:0] we_addr, raddr;

    lb_pix_side #(.LINE_PIXELS(LINE_PIXELS), .PTR_W(PTR_W)) pix_i (
        .clk(pix_clk), .rst_n(pix_rst_n), .hsync(hsync), .pix_en(pix_en),
        .tog(tog), .ren(ren), .rbank(rbank), .raddr(raddr), .pix_valid(pix_valid)
    );

    lb_toggle_sync sync_i (
        .clk(mem_clk), .rst_n(mem_rst_n), .tog_in(tog),
        .level(disp_level), .pulse(swap)
    );

    lb_mem_side #(
        .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .LINE_PIXELS(LINE_PIXELS),
        .NUM_LINES(NUM_LINES), .PTR_W(PTR_W), .LINE_W(LINE_W)
    ) mem_i (
        .clk(mem_clk), .rst_n(mem_rst_n), .base_addr(base_addr),
        .row_stride(row_stride), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .wr_valid(wr_valid), .swap(swap),
        .disp_level(disp_level), .we(we), .we_bank(we_bank), .we_addr(we_addr),
        .fill_done(fill_done), .late_line(late_line)
    );

    lb_dpram #(.W(PIX_W), .DEPTH(LINE_PIXELS), .PTR_W(PTR_W)) ram_i (
        .wclk(mem_clk), .wen(we), .wbank(we_bank), .waddr(we_addr), .wdata(wr_data),
        .rclk(pix_clk), .ren(ren), .rbank(rbank), .raddr(raddr), .rdata(pix_data)
    );

endmodule

// File: tb/scanline_pingpong_buf_tb_top.sv
module scanline_pingpong_buf_tb_top;
    localparam int NPIX  = 16;
    localparam int NLINE = 4;
    localparam logic [31:0] BASE   = 32'h0001_0000;
    localparam logic [15:0] STRIDE = 16'h0040;

    logic        mem_clk = 0, pix_clk = 0;
    logic        mem_rst_n = 0, pix_rst_n = 0;
    logic        req_ready = 0, wr_valid = 0, hsync = 0, pix_en = 0;
    logic [15:0] wr_data = '0;
    logic        req_valid, fill_done, late_line, pix_valid;
    logic [31:0] req_addr;
    logic [15:0] pix_data;

    int          n_chk = 0, n_fail = 0;
    logic [15:0] model [2][NPIX];
    int          db = 0;

    always #3.5 mem_clk = ~mem_clk;
    always #5   pix_clk = ~pix_clk;

    scanline_pingpong_buf #(
        .PIX_W(16), .LINE_PIXELS(NPIX), .NUM_LINES(NLINE), .ADDR_W(32), .STRIDE_W(16)
    ) dut_i (
        .mem_clk(mem_clk), .mem_rst_n(mem_rst_n), .base_addr(BASE), .row_stride(STRIDE),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .wr_valid(wr_valid), .wr_data(wr_data), .fill_done(fill_done),
        .late_line(late_line), .pix_clk(pix_clk), .pix_rst_n(pix_rst_n),
        .hsync(hsync), .pix_en(pix_en), .pix_valid(pix_valid), .pix_data(pix_data)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] addr_of(int ln);
        return BASE + 32'(ln % NLINE) * 32'(STRIDE);
    endfunction

    task automatic t_reset;
        repeat (3) @(negedge mem_clk);
        chk("R1", "req_valid", 32'(req_valid), 1);
        chk("R1", "req_addr", req_addr, BASE);
        chk("R1", "fill_done", 32'(fill_done), 0);
        chk("R1", "late_line", 32'(late_line), 0);
        @(negedge pix_clk);
        chk("R1", "pix_valid", 32'(pix_valid), 0);
    endtask

    task automatic t_hold_and_early_words;
        for (int i = 0; i < 4; i++) begin
            @(negedge mem_clk);
            wr_valid = 1'b1;
            wr_data  = 16'hDEAD;
        end
        @(negedge mem_clk);
        wr_valid = 1'b0;
        chk("R2", "req_valid held", 32'(req_valid), 1);
        chk("R2", "req_addr held", req_addr, BASE);
    endtask

    task automatic t_fill(int seq);
        chk("R2", "req_valid before accept", 32'(req_valid), 1);
        @(negedge mem_clk) req_ready = 1'b1;
        @(negedge mem_clk) req_ready = 1'b0;
        chk("R2", "req_valid after accept", 32'(req_valid), 0);
        for (int i = 0; i < NPIX; i++) begin
            @(negedge mem_clk);
            wr_valid = 1'b1;
            wr_data  = {8'(seq), 8'(i)};
            model[1 - db][i] = wr_data;
            if (i % 3 == 1) begin
                @(negedge mem_clk) wr_valid = 1'b0;
                chk("R3", "fill_done mid burst", 32'(fill_done), 0);
            end
        end
        @(negedge mem_clk) wr_valid = 1'b0;
        chk("R3", "fill_done after last", 32'(fill_done), 1);
        for (int i = 0; i < 3; i++) begin
            @(negedge mem_clk);
            wr_valid = 1'b1;
            wr_data  = 16'hBEEF;
        end
        @(negedge mem_clk) wr_valid = 1'b0;
        chk("R3", "fill_done holds", 32'(fill_done), 1);
    endtask

    task automatic t_swap(int exp_line, bit exp_late);
        @(negedge pix_clk) hsync = 1'b1;
        @(negedge pix_clk) hsync = 1'b0;
        chk("R5", "pix_valid after hsync", 32'(pix_valid), 0);
        db = 1 - db;
        repeat (8) @(negedge mem_clk);
        chk("R6", "req_valid after swap", 32'(req_valid), 1);
        chk("R10", "req_addr one line on", req_addr, addr_of(exp_line));
        chk("R8", "fill_done cleared", 32'(fill_done), 0);
        chk("R7", "late_line", 32'(late_line), 32'(exp_late));
    endtask

    task automatic t_show(string req);
        @(negedge pix_clk) pix_en = 1'b1;
        for (int i = 0; i < NPIX; i++) begin
            @(negedge pix_clk);
            if (i == NPIX - 1) pix_en = 1'b0;
            chk("R4", "pix_valid", 32'(pix_valid), 1);
            chk(req, $sformatf("pix_data[%0d]", i), 32'(pix_data), 32'(model[db][i]));
        end
        @(negedge pix_clk);
        chk("R4", "pix_valid idle", 32'(pix_valid), 0);
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge pix_clk);
        mem_rst_n = 1'b1;
        pix_rst_n = 1'b1;
        t_reset();
        t_hold_and_early_words();     // R9: junk must not show on line 0
        t_fill(1);
        t_swap(1, 1'b0);
        t_show("R9");
        t_fill(2);
        t_swap(2, 1'b0);
        t_show("R5");
        t_fill(3);
        t_swap(3, 1'b0);
        t_show("R3");
        t_fill(4);
        t_swap(4, 1'b0);              // R6: wraps to line 0
        chk("R6", "wrap address", req_addr, BASE);
        t_show("R5");
        t_swap(5, 1'b1);              // R7: no fill before swap
        t_show("R7");
        t_fill(5);
        t_swap(6, 1'b1);
        t_show("R5");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule